// File: doc/BRIEF.md
# Combining Circular Line-Address Buffer

This block keeps a short list of the physical cache lines that flagged producer instructions have written. Each time such an instruction retires, the core hands the block the physical byte address of the write. The block drops the offset within the line and keeps the line address. If a line is already held, the new write is merged into the entry that exists. When every slot is occupied, a new line replaces the oldest one, so the producer never stalls.

A consumer that forwards those lines to another core empties the block with a drain handshake. A start pulse takes a snapshot of the entries held at that moment. The block then shows the snapshot entries one at a time, oldest first. The consumer steps to the next entry with a next pulse, and each entry it steps past is freed. A one-cycle done pulse closes the drain. Lines that retire while a drain is running are kept for the following drain. A flush input, raised on an interrupt or an exception, throws away every entry because the address mapping may have changed.

Top module: `retire_line_buffer`

## Requirements
- R1: After reset the buffer holds no entry: drainValid and drainDone are 0, and a drain started right away produces drainDone with no entry shown.
- R2: On a cycle with retireValid high, the line address retireAddr[ADDR_W-1:LINE_OFS] is recorded. The low LINE_OFS offset bits (6 by default) do not affect which entry is used.
- R3: A retired line that matches a held entry creates no new entry, so a drain shows that line only once.
- R4: The buffer holds DEPTH (16) distinct lines. A new, non-matching line that arrives while all DEPTH slots are full replaces the oldest entry.
- R5: flush discards every entry and ends any running drain. A retire in the same cycle as flush is dropped.
- R6: From the cycle after drainStart, drainValid is 1 and drainAddr shows the oldest snapshot entry. Each drainNext frees that entry and, one cycle later, shows the next oldest.
- R7: When no snapshot entry is left, drainDone is 1 for exactly one cycle and drainValid is 0. If nothing retired during the drain, the buffer is then empty.
- R8: A line retired during a drain is not shown by that drain. It is shown by the next drain.
- R9: drainNext is ignored while drainValid is 0, and drainStart is ignored while a drain is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | A flagged instruction retires this cycle |
| retireAddr | input | ADDR_W (48) | Physical byte address written by that instruction |
| flush | input | 1 | Interrupt or exception: discard all entries |
| drainStart | input | 1 | Begin a drain of the entries held now |
| drainNext | input | 1 | Consumer has taken the shown entry |
| drainValid | output | 1 | drainAddr holds a snapshot entry |
| drainAddr | output | ADDR_W-LINE_OFS (42) | Oldest remaining snapshot line address |
| drainDone | output | 1 | One-cycle pulse: the drain is finished |

## Verification
The assertions assume that drainNext and flush arrive only from the clock domain of the block. They also assume that the consumer treats drainAddr as meaningful only while drainValid is high. The check that drainAddr stays stable while an entry waits also assumes that no retire or flush happens in that cycle, because a full buffer may replace the oldest entry. The stimulus changes inputs only at the falling edge. It raises drainNext only after seeing drainValid, except in the one test that sends it on purpose while the buffer is idle. It keeps retires apart from the stability windows that the checker watches.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  // per-cycle commands from control to the storage array
  typedef struct packed {
    logic wrEn;      // write the incoming line at the write index
    logic popEn;     // free the entry at the pop index
    logic clearAll;  // drop every entry
  } strobe_t;
endpackage

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 42,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lbuf_pkg::strobe_t    stb,
  input  logic [IDXW-1:0]      wrIdx,
  input  logic [TAG_W-1:0]     wrTag,
  input  logic [IDXW-1:0]      popIdx,
  output logic [TAG_W-1:0]     rdTag,
  output logic [DEPTH-1:0]     hitVec
);
  logic [DEPTH-1:0] valid;
  logic [TAG_W-1:0] tags [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAll) begin
      valid <= '0;
    end else begin
      if (stb.popEn) valid[popIdx] <= 1'b0;
      if (stb.wrEn)  valid[wrIdx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) tags[wrIdx] <= wrTag;
  end

  // parallel compare against every held line
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hitVec[g] = valid[g] && (tags[g] == wrTag);
  end

  assign rdTag = tags[popIdx];
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               retireValid,
  input  logic               flush,
  input  logic               drainStart,
  input  logic               drainNext,
  input  logic [DEPTH-1:0]   hitVec,
  output lbuf_pkg::strobe_t  stb,
  output logic [IDXW-1:0]    wrIdx,
  output logic [IDXW-1:0]    popIdx,
  output logic               drainValid,
  output logic               drainDone
);
  logic [IDXW-1:0] head, tail;
  logic [CNTW-1:0] count, left;
  logic            draining;
  logic            pop, ins, ovw, hit, full, startNow;
  logic [DEPTH-1:0] popMask;

  function automatic logic [IDXW-1:0] nextIdx(input logic [IDXW-1:0] i);
    return (i == IDXW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    pop      = draining && (left != '0) && drainNext && !flush;
    popMask  = pop ? (DEPTH'(1) << head) : '0;
    hit      = |(hitVec & ~popMask);
    ins      = retireValid && !flush && !hit;
    full     = (count == CNTW'(DEPTH));
    ovw      = ins && full && !pop;
    startNow = !draining && drainStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head <= '0; tail <= '0; count <= '0; left <= '0; draining <= 1'b0;
    end else if (flush) begin
      head <= '0; tail <= '0; count <= '0; left <= '0;
      draining <= startNow || (draining && left != '0);
    end else begin
      if (pop || ovw) head <= nextIdx(head);
      if (ins)        tail <= nextIdx(tail);
      count <= count + CNTW'(ins) - CNTW'(pop) - CNTW'(ovw);
      if (startNow) begin
        draining <= 1'b1;
        left     <= count - CNTW'(ovw);
      end else if (draining) begin
        if (left == '0) draining <= 1'b0;
        else left <= left - CNTW'(pop) - CNTW'(ovw);
      end
    end
  end

  assign stb.wrEn     = ins;
  assign stb.popEn    = pop;
  assign stb.clearAll = flush;
  assign wrIdx        = tail;
  assign popIdx       = head;
  assign drainValid   = draining && (left != '0);
  assign drainDone    = draining && (left == '0);
endmodule

// File: rtl/retire_line_buffer.sv
module retire_line_buffer #(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 48,
  parameter int LINE_OFS = 6,
  localparam int TAG_W = ADDR_W - LINE_OFS,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] retireAddr,
  input  logic              flush,
  input  logic              drainStart,
  input  logic              drainNext,
  output logic              drainValid,
  output logic [TAG_W-1:0]  drainAddr,
  output logic              drainDone
);
  lbuf_pkg::strobe_t stb;
  logic [IDXW-1:0]   wrIdx, popIdx;
  logic [DEPTH-1:0]  hitVec;
  logic [TAG_W-1:0]  lineTag;

  assign lineTag = retireAddr[ADDR_W-1:LINE_OFS];

  lbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .flush(flush),
    .drainStart(drainStart), .drainNext(drainNext), .hitVec(hitVec),
    .stb(stb), .wrIdx(wrIdx), .popIdx(popIdx),
    .drainValid(drainValid), .drainDone(drainDone)
  );

  lbuf_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .wrTag(lineTag),
    .popIdx(popIdx), .rdTag(drainAddr), .hitVec(hitVec)
  );
endmodule

// File: rtl/lbuf_checker.sv
module lbuf_checker #(
  parameter int ADDR_W = 48,
  parameter int TAG_W  = 42
) (
  input logic              clk,
  input logic              rstN,
  input logic              retireValid,
  input logic [ADDR_W-1:0] retireAddr,
  input logic              flush,
  input logic              drainStart,
  input logic              drainNext,
  input logic              drainValid,
  input logic [TAG_W-1:0]  drainAddr,
  input logic              drainDone
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |=> !drainDone); // R7
  AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(drainValid && drainDone)); // R7
  AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !drainValid); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (drainValid && !drainNext && !flush && !retireValid) |=> (drainValid && $stable(drainAddr))); // R6
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!drainValid && !drainDone && drainStart && !flush) |=> (drainValid || drainDone)); // R9
endmodule

bind retire_line_buffer lbuf_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rstN(rstN), .retireValid(retireValid), .retireAddr(retireAddr),
  .flush(flush), .drainStart(drainStart), .drainNext(drainNext),
  .drainValid(drainValid), .drainAddr(drainAddr), .drainDone(drainDone)
);

// File: tb/test_retire_line_buffer.sv
module test_retire_line_buffer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retireValid = 1'b0, flush = 1'b0, drainStart = 1'b0, drainNext = 1'b0;
  logic [47:0] retireAddr = '0;
  logic drainValid, drainDone;
  logic [41:0] drainAddr;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;  // 125 MHz

  retire_line_buffer i_retire_line_buffer (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retireAddr(retireAddr),
    .flush(flush), .drainStart(drainStart), .drainNext(drainNext),
    .drainValid(drainValid), .drainAddr(drainAddr), .drainDone(drainDone)
  );

  typedef struct packed {
    logic rv; logic [47:0] ad; logic fl; logic st; logic nx;
    logic ev; logic [41:0] ea; logic ed;
  } vec_t;

  // line 0x10 at offsets 3 and 9, line 0x20
  localparam vec_t VECS [10] = '{
    '{1'b1, 48'h403, 1'b0, 1'b0, 1'b0, 1'b0, 42'h0,  1'b0}, // R2 add line 0x10
    '{1'b1, 48'h800, 1'b0, 1'b0, 1'b0, 1'b0, 42'h0,  1'b0}, // R2 add line 0x20
    '{1'b1, 48'h409, 1'b0, 1'b0, 1'b0, 1'b0, 42'h0,  1'b0}, // R3 same line, new offset
    '{1'b0, 48'h0,   1'b0, 1'b1, 1'b0, 1'b1, 42'h10, 1'b0}, // R6 oldest shown
    '{1'b0, 48'h0,   1'b0, 1'b0, 1'b1, 1'b1, 42'h20, 1'b0}, // R6 next
    '{1'b0, 48'h0,   1'b0, 1'b0, 1'b0, 1'b1, 42'h20, 1'b0}, // R6 held
    '{1'b0, 48'h0,   1'b0, 1'b0, 1'b1, 1'b0, 42'h0,  1'b1}, // R3 no duplicate, R7 done
    '{1'b0, 48'h0,   1'b0, 1'b0, 1'b0, 1'b0, 42'h0,  1'b0}, // R7 one cycle
    '{1'b0, 48'h0,   1'b0, 1'b1, 1'b0, 1'b0, 42'h0,  1'b1}, // R7 empty afterwards
    '{1'b0, 48'h0,   1'b0, 1'b0, 1'b0, 1'b0, 42'h0,  1'b0}
  };

  task automatic chk(input string tag, input logic [41:0] act, input logic [41:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // inputs change at negedge; outputs sampled at the following negedge
  task automatic step(input logic rv, input logic [47:0] ad, input logic fl,
                      input logic st, input logic nx);
    retireValid = rv; retireAddr = ad; flush = fl; drainStart = st; drainNext = nx;
    @(posedge clk);
    @(negedge clk);
    retireValid = 1'b0; flush = 1'b0; drainStart = 1'b0; drainNext = 1'b0;
  endtask

  task automatic addLine(input logic [41:0] ln);
    step(1'b1, {ln, 6'h15}, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic expShow(input string tag, input logic [41:0] ln);
    chk({tag, " valid"}, 42'(drainValid), 42'd1);
    chk({tag, " addr"}, drainAddr, ln);
  endtask

  task automatic expDone(input string tag);
    chk({tag, " valid"}, 42'(drainValid), 42'd0);
    chk({tag, " done"}, 42'(drainDone), 42'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 42'(drainValid), 42'd0);
    chk("R1 done", 42'(drainDone), 42'd0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    expDone("R1 empty drain");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);

    // vector table: R2 R3 R6 R7
    for (int i = 0; i < 10; i++) begin
      step(VECS[i].rv, VECS[i].ad, VECS[i].fl, VECS[i].st, VECS[i].nx);
      chk($sformatf("R6 vec%0d valid", i), 42'(drainValid), 42'(VECS[i].ev));
      if (VECS[i].ev) chk($sformatf("R2 vec%0d addr", i), drainAddr, VECS[i].ea);
      chk($sformatf("R7 vec%0d done", i), 42'(drainDone), 42'(VECS[i].ed));
    end

    // R4 overflow: lines 1..17, oldest (1) replaced
    for (int i = 1; i <= 17; i++) addLine(42'(i));
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    for (int i = 2; i <= 17; i++) begin
      expShow($sformatf("R4 entry%0d", i), 42'(i));
      step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    end
    expDone("R4 end");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);

    // R5 flush with a retire in the same cycle
    addLine(42'h31); addLine(42'h32); addLine(42'h33);
    step(1'b1, {42'h39, 6'h0}, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    expDone("R5 flushed");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);

    // R5 flush during a drain
    addLine(42'h41); addLine(42'h42);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    expShow("R5 pre-flush", 42'h41);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    expDone("R5 flush ends drain");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);

    // R8 retire during drain goes to the next drain
    addLine(42'h51); addLine(42'h52);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    expShow("R8 first", 42'h51);
    step(1'b1, {42'h53, 6'h0}, 1'b0, 1'b0, 1'b1);
    expShow("R8 second", 42'h52);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    expDone("R8 deferred not shown");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    expShow("R8 next drain", 42'h53);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    expDone("R8 next done");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);

    // R9 drainNext while idle, drainStart during a drain
    addLine(42'h61); addLine(42'h62);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    expShow("R9 next ignored", 42'h61);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    expShow("R9 start ignored", 42'h62);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    expDone("R9 done");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule